// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device end of a three-wire serial memory link. A host drives a chip select, a serial clock and a data-in line; the block answers on a data-out line with its own output enable. Every signal is sampled by the on-chip system clock, and a bit is taken at a rising edge of the serial clock. After a start bit the block collects a two-bit opcode, an address and any write data. It then runs one of seven commands against a small internal byte array: read, write, erase, erase-all, write-all, and the enable and disable of programming.

An organization input selects 16-bit words (high) or 8-bit words (low). Programming is guarded by a write-enable latch and takes a fixed number of system clocks. During that time the data-out line reports busy (low) and then ready (high) while chip select is high. The serial link has no back-pressure: the host paces every bit, and a command that arrives while programming runs is dropped rather than held off.

Top module: `mw_eeprom`

## Requirements
- R1: Bits are taken from `di` on rising `sclk` edges while `cs` is high. The start bit is the first such edge with `di` high, so earlier edges with `di` low cause no operation.
- R2: The two bits after the start bit are the opcode: 10 read, 01 write, 11 erase, 00 special. For special commands the two most significant address bits select 11 enable, 00 disable, 10 erase-all or 01 write-all. The remaining address bits are don't care.
- R3: With `org` high, words are 16 bits wide and addresses are AW16 bits. With `org` low, words are 8 bits and addresses are AW16+1 bits. A 16-bit word n holds byte 2n in its low half and byte 2n+1 in its high half. All fields are sent MSB first.
- R4: A read enables `dout` with one zero bit right after the last address bit. Each following `sclk` rise presents the next data bit, MSB first. The rise after the last data bit releases `dout_oe`.
- R5: A write with the latch set stores the data word after PROG_CYCLES system clocks. The programming cycle starts on the rise that carries the last data bit.
- R6: After reset the write-enable latch is clear. Write, erase, erase-all and write-all then start no programming and change no data, while a read still returns the stored data.
- R7: The enable command sets the latch and the disable command clears it. The latch holds its value until the other command or a reset.
- R8: Erase sets the addressed word to all ones. Erase-all sets every byte to all ones. Write-all stores the data word in every word of the current organization.
- R9: While programming runs and `cs` is high, `dout_oe` is 1 and `dout` is 0. After it completes, `dout` is 1 while `cs` is high, until a start bit arrives or `cs` falls.
- R10: `dout_oe` is 0 whenever `cs` is low, including right after reset.
- R11: If `cs` falls before the last required bit of a command, the command does nothing.
- R12: While programming runs, start bits and serial bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from host |
| di | input | 1 | Serial data from host |
| org | input | 1 | Word size select: 1 = 16-bit, 0 = 8-bit |
| dout | output | 1 | Serial data / ready-busy status to host |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
A new command can arrive while a programming cycle from the previous one is still running. The bench holds chip select high right after a write and clocks in a complete start bit and read opcode while the block is busy. It expects `dout` to stay in the busy state through those edges, then switch to ready, and the written word to read back unchanged with no read having begun. A second case is the last bit of a command falling together with a drop of chip select. The bench cuts a write one data bit short and checks that `dout_oe` stays low and the stored word is untouched.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ
  } mw_state_e;

  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_ERASE   = 2'b11;

  localparam logic [1:0] SUB_DISABLE = 2'b00;
  localparam logic [1:0] SUB_WRALL   = 2'b01;
  localparam logic [1:0] SUB_ERALL   = 2'b10;
  localparam logic [1:0] SUB_ENABLE  = 2'b11;
endpackage

// File: rtl/mw_pin_edge.sv
module mw_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  output logic sclk_rise,
  output logic cs_fall
);
  logic sclk_q;
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs;
    end
  end

  assign sclk_rise = sclk & ~sclk_q;
  assign cs_fall   = cs_q & ~cs;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int PROG_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic done
);
  localparam int TW = $clog2(PROG_CYCLES + 1);

  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        busy   <= 1'b1;
        remain <= TW'(PROG_CYCLES - 1);
      end else if (busy) begin
        if (remain == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int AW16 = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            org,
  input  logic [AW16:0]   rd_addr,
  output logic [15:0]     rd_word,
  input  logic            go,
  input  logic            go_all,
  input  logic [AW16:0]   go_addr,
  input  logic [15:0]     go_data,
  input  logic            commit
);
  localparam int AW8    = AW16 + 1;
  localparam int NBYTES = 1 << AW8;

  logic [7:0]     mem [NBYTES];
  logic [AW8-1:0] p_addr;
  logic [15:0]    p_data;
  logic           p_all;
  logic           p_org;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_addr <= '0;
      p_data <= '0;
      p_all  <= 1'b0;
      p_org  <= 1'b0;
    end else if (go) begin
      p_addr <= go_addr;
      p_data <= go_data;
      p_all  <= go_all;
      p_org  <= org;
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam logic [AW8-1:0] IDX = AW8'(i);
    logic hit;
    logic [7:0] val;
    assign hit = p_all | (p_org ? (IDX[AW8-1:1] == p_addr[AW16-1:0])
                                : (IDX == p_addr));
    assign val = (p_org && IDX[0]) ? p_data[15:8] : p_data[7:0];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= 8'h00;
      else if (commit && hit)
        mem[i] <= val;
    end
  end

  always_comb begin
    if (org)
      rd_word = {mem[{rd_addr[AW16-1:0], 1'b1}], mem[{rd_addr[AW16-1:0], 1'b0}]};
    else
      rd_word = {mem[rd_addr], 8'h00};
  end
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int AW16 = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          di,
  input  logic          org,
  input  logic          sclk_rise,
  input  logic          busy,
  input  logic [15:0]   rd_word,
  output logic [AW16:0] rd_addr,
  output logic          go,
  output logic          go_all,
  output logic [AW16:0] go_addr,
  output logic [15:0]   go_data,
  output logic          wen,
  output logic          start,
  output logic          in_read,
  output logic          st_idle,
  output logic          rd_bit
);
  localparam int AW8 = AW16 + 1;

  mw_state_e      st;
  logic [4:0]     cnt;
  logic [1:0]     opc;
  logic [AW8-1:0] addr;
  logic [15:0]    data;
  logic [15:0]    rsh;
  logic [AW8-1:0] na;
  logic [15:0]    nd;
  logic [1:0]     sub;
  logic [4:0]     alen;
  logic [4:0]     dlen;

  assign na   = {addr[AW8-2:0], di};
  assign nd   = {data[14:0], di};
  assign sub  = org ? na[AW16-1 -: 2] : na[AW8-1 -: 2];
  assign alen = org ? 5'(AW16) : 5'(AW8);
  assign dlen = org ? 5'd16 : 5'd8;

  assign rd_addr = na;
  assign start   = (st == ST_IDLE) && cs && sclk_rise && di && !busy;
  assign in_read = (st == ST_READ);
  assign st_idle = (st == ST_IDLE);
  assign rd_bit  = (cnt == 5'd0) ? 1'b0 : rsh[15];
  assign go_addr = addr;
  assign go_data = data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      opc    <= '0;
      addr   <= '0;
      data   <= '0;
      rsh    <= '0;
      wen    <= 1'b0;
      go     <= 1'b0;
      go_all <= 1'b0;
    end else begin
      go <= 1'b0;
      if (!cs) begin
        st <= ST_IDLE;
      end else if (sclk_rise) begin
        case (st)
          ST_IDLE: begin
            if (di && !busy) begin
              st   <= ST_OPC;
              cnt  <= '0;
              addr <= '0;
            end
          end
          ST_OPC: begin
            opc <= {opc[0], di};
            if (cnt == 5'd1) begin
              st  <= ST_ADDR;
              cnt <= '0;
            end else begin
              cnt <= cnt + 5'd1;
            end
          end
          ST_ADDR: begin
            addr <= na;
            if (cnt == alen - 5'd1) begin
              cnt <= '0;
              st  <= ST_IDLE;
              case (opc)
                OP_READ: begin
                  st  <= ST_READ;
                  rsh <= rd_word;
                end
                OP_WRITE: st <= ST_DATA;
                OP_ERASE: begin
                  data   <= 16'hFFFF;
                  go_all <= 1'b0;
                  go     <= wen;
                end
                default: begin
                  case (sub)
                    SUB_ENABLE:  wen <= 1'b1;
                    SUB_DISABLE: wen <= 1'b0;
                    SUB_ERALL: begin
                      data   <= 16'hFFFF;
                      go_all <= 1'b1;
                      go     <= wen;
                    end
                    default: st <= ST_DATA;
                  endcase
                end
              endcase
            end else begin
              cnt <= cnt + 5'd1;
            end
          end
          ST_DATA: begin
            data <= nd;
            if (cnt == dlen - 5'd1) begin
              st     <= ST_IDLE;
              cnt    <= '0;
              go_all <= (opc == OP_SPECIAL);
              go     <= wen;
            end else begin
              cnt <= cnt + 5'd1;
            end
          end
          ST_READ: begin
            if (cnt == dlen) begin
              st <= ST_IDLE;
            end else begin
              if (cnt != 5'd0) rsh <= {rsh[14:0], 1'b0};
              cnt <= cnt + 5'd1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int AW16        = 6,
  parameter int PROG_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic di,
  input  logic org,
  output logic dout,
  output logic dout_oe
);
  logic          sclk_rise;
  logic          cs_fall;
  logic [AW16:0] rd_addr;
  logic [15:0]   rd_word;
  logic          go;
  logic          go_all;
  logic [AW16:0] go_addr;
  logic [15:0]   go_data;
  logic          wen;
  logic          start;
  logic          in_read;
  logic          st_idle;
  logic          rd_bit;
  logic          busy;
  logic          done;
  logic          rdy;

  mw_pin_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk),
    .sclk_rise(sclk_rise), .cs_fall(cs_fall)
  );

  mw_ctrl #(.AW16(AW16)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .di(di), .org(org),
    .sclk_rise(sclk_rise), .busy(busy), .rd_word(rd_word),
    .rd_addr(rd_addr), .go(go), .go_all(go_all), .go_addr(go_addr),
    .go_data(go_data), .wen(wen), .start(start), .in_read(in_read),
    .st_idle(st_idle), .rd_bit(rd_bit)
  );

  mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done)
  );

  mw_array #(.AW16(AW16)) u_array (
    .clk(clk), .rst_n(rst_n), .org(org), .rd_addr(rd_addr),
    .rd_word(rd_word), .go(go), .go_all(go_all), .go_addr(go_addr),
    .go_data(go_data), .commit(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdy <= 1'b0;
    else if (done)
      rdy <= 1'b1;
    else if (start || cs_fall)
      rdy <= 1'b0;
  end

  assign dout_oe = cs & (in_read | busy | rdy);
  assign dout    = dout_oe & (in_read ? rd_bit : ~busy);
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic dout,
  input logic dout_oe,
  input logic busy,
  input logic wen,
  input logic in_read,
  input logic st_idle
);
  // R10
  deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !dout_oe);

  // R12
  start_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && st_idle |=> st_idle);

  // R6
  prog_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wen);

  // R5
  prog_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> st_idle);

  // R4
  read_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_read) && cs |-> dout_oe && !dout);

  // R11
  read_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !in_read);
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .dout(dout), .dout_oe(dout_oe),
  .busy(busy), .wen(wen), .in_read(in_read), .st_idle(st_idle)
);

// File: tb/mw_eeprom_bench.sv
module mw_eeprom_bench;
  localparam int AW16 = 6;
  localparam int PROG = 20;
  localparam int NB   = 1 << (AW16 + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sclk = 1'b0;
  logic di = 1'b0;
  logic org = 1'b1;
  logic dout;
  logic dout_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [NB];

  always #2 clk = ~clk;

  mw_eeprom #(.AW16(AW16), .PROG_CYCLES(PROG)) u_mw_eeprom (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .di(di), .org(org),
    .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int alen(input logic o);
    return o ? AW16 : AW16 + 1;
  endfunction

  function automatic int exp_word(input logic o, input int a);
    if (o) return {model[2*a+1], model[2*a]};
    return int'(model[a]);
  endfunction

  function automatic void model_put(input logic o, input int a, input int v);
    if (o) begin
      model[2*a]   = v[7:0];
      model[2*a+1] = v[15:8];
    end else begin
      model[a] = v[7:0];
    end
  endfunction

  task automatic sbit(input logic b);
    di = b;
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic deselect();
    cs = 1'b0;
    di = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic hdr(input logic o, input logic [1:0] op, input int a);
    org = o;
    cs = 1'b1;
    sbit(1'b1);
    sbit(op[1]);
    sbit(op[0]);
    for (int i = alen(o) - 1; i >= 0; i--) sbit(a[i]);
  endtask

  task automatic send_data(input logic o, input int v, input int nbits);
    for (int i = (o ? 15 : 7); i > (o ? 15 : 7) - nbits; i--) sbit(v[i]);
  endtask

  task automatic rd(input logic o, input int a, input string req);
    int v = 0;
    hdr(o, 2'b10, a);
    chk(dout_oe && !dout, "R4 dummy", {dout_oe, dout}, 2);
    for (int i = 0; i < (o ? 16 : 8); i++) begin
      sbit(1'b0);
      v = (v << 1) | int'(dout);
    end
    chk(v == exp_word(o, a), req, v, exp_word(o, a));
    sbit(1'b0);
    chk(!dout_oe, "R4 release", dout_oe, 0);
    deselect();
  endtask

  task automatic prog_end(input bit expect_prog, input string req);
    if (expect_prog) begin
      chk(dout_oe && !dout, {req, " busy R9"}, {dout_oe, dout}, 2);
      repeat (PROG + 4) @(negedge clk);
      chk(dout_oe && dout, {req, " ready R9"}, {dout_oe, dout}, 3);
    end else begin
      chk(!dout_oe, {req, " no prog R6"}, dout_oe, 0);
    end
    deselect();
    chk(!dout_oe, "R10 deselect", dout_oe, 0);
  endtask

  task automatic wr(input logic o, input int a, input int v, input bit en);
    hdr(o, 2'b01, a);
    send_data(o, v, o ? 16 : 8);
    prog_end(en, "R5 write");
    if (en) model_put(o, a, v);
  endtask

  task automatic special(input logic o, input logic [1:0] s);
    hdr(o, 2'b00, int'(s) << (alen(o) - 2));
  endtask

  initial begin
    int seed_dummy;
    for (int i = 0; i < NB; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dout_oe, "R10 reset", dout_oe, 0);

    // R6: latch clear after reset, read still works, write ignored
    rd(1'b1, 0, "R6 read with latch clear");
    wr(1'b1, 3, 16'hBEEF, 1'b0);
    rd(1'b1, 3, "R6 write ignored");

    // R1: leading zero clocks before start cause nothing, then enable
    cs = 1'b1;
    sbit(1'b0);
    sbit(1'b0);
    special(1'b1, 2'b11);
    deselect();
    wr(1'b1, 5, 16'hA5C3, 1'b1);
    rd(1'b1, 5, "R1 R5 write after leading zeros");

    // R3: 8-bit mode, extra address bit, byte placement
    wr(1'b0, 127, 8'h3C, 1'b1);
    rd(1'b0, 127, "R3 byte read");
    rd(1'b1, 63, "R3 word holds byte 127 high");
    rd(1'b0, 10, "R3 low byte of word 5");

    // R11: abort one data bit early
    hdr(1'b1, 2'b01, 1);
    send_data(1'b1, 16'hFFFF, 15);
    deselect();
    chk(!dout_oe, "R11 no busy after abort", dout_oe, 0);
    rd(1'b1, 1, "R11 word unchanged");

    // R12: start and opcode during programming are ignored
    hdr(1'b1, 2'b01, 2);
    send_data(1'b1, 16'h1357, 16);
    sbit(1'b1);
    sbit(1'b1);
    sbit(1'b0);
    chk(dout_oe && !dout, "R12 still busy", {dout_oe, dout}, 2);
    repeat (PROG) @(negedge clk);
    chk(dout_oe && dout, "R12 ready, no read", {dout_oe, dout}, 3);
    deselect();
    model_put(1'b1, 2, 16'h1357);
    rd(1'b1, 2, "R12 data intact");

    // R8: erase, erase-all, write-all
    hdr(1'b1, 2'b11, 5);
    prog_end(1'b1, "R8 erase");
    model_put(1'b1, 5, 16'hFFFF);
    rd(1'b1, 5, "R8 erase word");
    special(1'b1, 2'b10);
    prog_end(1'b1, "R8 eral");
    for (int i = 0; i < NB; i++) model[i] = 8'hFF;
    rd(1'b0, 0, "R8 eral byte 0");
    rd(1'b1, 40, "R8 eral word 40");
    special(1'b1, 2'b01);
    send_data(1'b1, 16'h1234, 16);
    prog_end(1'b1, "R8 wral");
    for (int i = 0; i < NB / 2; i++) model_put(1'b1, i, 16'h1234);
    rd(1'b1, 0, "R8 wral first");
    rd(1'b1, 63, "R8 wral last");

    // R7: disable blocks, re-enable allows
    special(1'b0, 2'b00);
    deselect();
    wr(1'b0, 9, 8'h77, 1'b0);
    rd(1'b0, 9, "R7 disabled write ignored");
    special(1'b0, 2'b11);
    deselect();

    // R2: random mix of opcodes against the model
    seed_dummy = $urandom(32'd1234);
    for (int n = 0; n < 60; n++) begin
      logic o = 1'($urandom() & 1);
      int a = int'($urandom() % (o ? NB / 2 : NB));
      int k = int'($urandom() % 3);
      if (k == 0) begin
        rd(o, a, "R2 random read");
      end else if (k == 1) begin
        wr(o, a, int'($urandom() & 16'hFFFF), 1'b1);
      end else begin
        hdr(o, 2'b11, a);
        prog_end(1'b1, "R2 R8 random erase");
        model_put(o, a, 16'hFFFF);
        rd(o, a, "R2 R8 after erase");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule